// File: doc/BRIEF.md
# Banked Scratchpad RAM with Bit Access

This block is the 128-byte internal data RAM of a small 8-bit controller. One port takes one request per cycle. An operation code picks how the 7-bit address field is read. It can be a plain byte address. It can be a working-register number, which is placed in the active group of eight registers. It can be a bit address, which picks one bit inside a fixed window of sixteen bytes.

Register numbers go through a two-bit active-bank register. That register clears to bank 0 on reset and loads from `bank_sel` whenever `bank_wr` is high. Bit writes use a read-modify-write of the containing byte, done in a single cycle. Read results are registered. They appear one cycle after the request, together with a one-cycle `rd_valid` pulse, and then stay on `rd_data` until the next read.

Top module: `spad_ram`

## Requirements
- R1: A byte write (op 2) stores `req_wdata` at byte `req_addr[6:0]`. A byte read (op 1) returns that byte on `rd_data` at the clock edge after the request, with `rd_valid` high for exactly that cycle.
- R2: Bit 7 of `req_addr` is ignored for every operation, so byte address 85h reaches the same byte as 05h.
- R3: A register read (op 3) or write (op 4) reaches byte `{bank, req_addr[2:0]}`, which always lies within 00h–1Fh. Those same bytes can also be reached through byte operations, whatever the active bank is.
- R4: The active bank is 0 after reset. When `bank_wr` is high, the bank is loaded from `bank_sel`, and it first steers register requests in the following cycle. A register request made in the same cycle as the load still uses the old bank.
- R5: A bit write (op 6) with bit address n writes `req_bit` into bit n[2:0] of byte 20h + n[6:3]. The other seven bits of that byte are left unchanged, and the whole operation takes one cycle.
- R6: A bit read (op 5) returns the addressed bit in `rd_data[0]`, with `rd_data[7:1]` zero, one cycle after the request.
- R7: The same address value is a byte address for byte operations and a bit address for bit operations. For example, byte read 0Ah and bit read 0Ah reach different storage.
- R8: `rd_data` resets to 00h and `rd_valid` resets to 0. `rd_data` keeps its value across every cycle that carries no read.
- R9: Op 0 (idle) and op 7 (reserved) change no memory byte and raise no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_op | input | 3 | Operation: 0 idle, 1 byte rd, 2 byte wr, 3 reg rd, 4 reg wr, 5 bit rd, 6 bit wr, 7 reserved |
| req_addr | input | 8 | Byte address, register number (bits 2:0) or bit address; bit 7 is ignored |
| req_wdata | input | 8 | Write data for byte and register writes |
| req_bit | input | 1 | Value stored by a bit write |
| bank_wr | input | 1 | Load the active bank from `bank_sel` |
| bank_sel | input | 2 | New active bank value |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a fresh read result |

## Verification
On every cycle the assertions check the things visible at the block boundary. These are: the read-valid timing, `rd_data` holding its value between reads, register requests landing in the low 32 bytes, bit requests landing in the 20h–2Fh window, a bit write flipping at most one bit of its byte, and the bank register's load and hold rules. Only the bench scenarios can show which byte and bit were actually changed. That covers the placement of a register number under a given bank, the old bank applying when a bank load and a register request share a cycle, and bit and byte views of one address reaching different storage. They also show the address top bit being ignored, and an idle or reserved request leaving the contents unchanged. For these the bench compares against its own memory model on every clock.

// File: rtl/spad_pkg.sv
`timescale 1ns/1ps
package spad_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_BYTE_R = 3'd1,
    OP_BYTE_W = 3'd2,
    OP_REG_R  = 3'd3,
    OP_REG_W  = 3'd4,
    OP_BIT_R  = 3'd5,
    OP_BIT_W  = 3'd6,
    OP_RSVD   = 3'd7
  } spad_op_e;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'd0,
    MODE_REG  = 2'd1,
    MODE_BIT  = 2'd2
  } spad_mode_e;

endpackage

// File: rtl/spad_rst_sync.sv
`timescale 1ns/1ps
module spad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/spad_bank_reg.sv
`timescale 1ns/1ps
module spad_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load_en) bank_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

endmodule

// File: rtl/spad_addr_map.sv
`timescale 1ns/1ps
module spad_addr_map
  import spad_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int RN_W      = 3,
  parameter int BIT_BASE  = 32,
  localparam int POS_W    = $clog2(DATA_W),
  localparam int BOFF_W   = ADDR_W - POS_W
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W:0]   addr_in,
  input  logic [BANK_W-1:0] bank,
  output logic              rd_en,
  output logic              wr_en,
  output spad_mode_e        mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [POS_W-1:0]  bit_pos
);

  spad_op_e          op_e;
  logic [ADDR_W-1:0] a7;
  logic              unused_top;
  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] bit_byte;
  logic [BOFF_W-1:0] bit_off;

  assign op_e       = spad_op_e'(op);
  assign a7         = addr_in[ADDR_W-1:0];
  assign unused_top = addr_in[ADDR_W];

  assign reg_addr = ADDR_W'({bank, a7[RN_W-1:0]});
  assign bit_off  = a7[ADDR_W-1:POS_W];
  assign bit_byte = ADDR_W'(BIT_BASE) + ADDR_W'(bit_off);

  always_comb begin
    rd_en = 1'b0;
    wr_en = 1'b0;
    mode  = MODE_BYTE;
    unique case (op_e)
      OP_BYTE_R: begin rd_en = 1'b1; mode = MODE_BYTE; end
      OP_BYTE_W: begin wr_en = 1'b1; mode = MODE_BYTE; end
      OP_REG_R:  begin rd_en = 1'b1; mode = MODE_REG;  end
      OP_REG_W:  begin wr_en = 1'b1; mode = MODE_REG;  end
      OP_BIT_R:  begin rd_en = 1'b1; mode = MODE_BIT;  end
      OP_BIT_W:  begin wr_en = 1'b1; mode = MODE_BIT;  end
      default:   begin rd_en = 1'b0; wr_en = 1'b0;     end
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_REG: mem_addr = reg_addr;
      MODE_BIT: mem_addr = bit_byte;
      default:  mem_addr = a7;
    endcase
  end

  assign bit_pos = a7[POS_W-1:0];

endmodule

// File: rtl/spad_array.sv
`timescale 1ns/1ps
module spad_array
  import spad_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  spad_mode_e        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bit_val,
  output logic [DATA_W-1:0] old_byte,
  output logic [DATA_W-1:0] new_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_d;
  logic              vld_d;
  logic              sel_bit;

  assign old_byte = mem[addr];
  assign sel_bit  = old_byte[bit_pos];

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_merge
      assign merged[b] = (bit_pos == POS_W'(b)) ? bit_val : old_byte[b];
    end
  endgenerate

  assign new_byte = (mode == MODE_BIT) ? merged : wdata;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= new_byte;
  end

  always_comb begin
    rd_d  = rd_data;
    vld_d = 1'b0;
    if (rd_en) begin
      vld_d = 1'b1;
      if (mode == MODE_BIT) rd_d = DATA_W'(sel_bit);
      else                  rd_d = old_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_d;
      rd_valid <= vld_d;
    end
  end

endmodule

// File: rtl/spad_ram.sv
`timescale 1ns/1ps
module spad_ram
  import spad_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int RN_W     = 3,
  parameter int BIT_BASE = 32,
  parameter int SYNC_STG = 2,
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_bit,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic              rst_n_s;
  logic [BANK_W-1:0] bank_q;
  logic              map_rd;
  logic              mem_we;
  spad_mode_e        map_mode;
  logic [ADDR_W-1:0] mem_addr;
  logic [POS_W-1:0]  map_pos;
  logic [DATA_W-1:0] old_byte;
  logic [DATA_W-1:0] new_byte;

  spad_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  spad_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_en  (bank_wr),
    .load_val (bank_sel),
    .bank_q   (bank_q)
  );

  spad_addr_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .RN_W(RN_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .op       (req_op),
    .addr_in  (req_addr),
    .bank     (bank_q),
    .rd_en    (map_rd),
    .wr_en    (mem_we),
    .mode     (map_mode),
    .mem_addr (mem_addr),
    .bit_pos  (map_pos)
  );

  spad_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_en    (map_rd),
    .wr_en    (mem_we),
    .mode     (map_mode),
    .addr     (mem_addr),
    .bit_pos  (map_pos),
    .wdata    (req_wdata),
    .bit_val  (req_bit),
    .old_byte (old_byte),
    .new_byte (new_byte),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/spad_ram_chk.sv
`timescale 1ns/1ps
module spad_ram_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic [2:0] req_op,
  input logic       bank_wr,
  input logic [1:0] bank_sel,
  input logic [1:0] bank_q,
  input logic       mem_we,
  input logic [6:0] mem_addr,
  input logic [7:0] old_byte,
  input logic [7:0] new_byte,
  input logic [7:0] rd_data,
  input logic       rd_valid
);

  logic is_read;
  assign is_read = (req_op == 3'd1) || (req_op == 3'd3) || (req_op == 3'd5);

  assert_read_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    is_read |=> rd_valid);

  assert_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !is_read |=> !rd_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !is_read |=> $stable(rd_data));

  assert_reg_window_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_op == 3'd3 || req_op == 3'd4) |-> (mem_addr < 7'h20));

  assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    bank_wr |=> (bank_q == $past(bank_sel)));

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bank_wr |=> $stable(bank_q));

  assert_bit_window_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_op == 3'd5 || req_op == 3'd6) |-> (mem_addr[6:4] == 3'b010));

  assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_op == 3'd6) |-> ($countones(new_byte ^ old_byte) <= 1));

  assert_bit_read_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_op == 3'd5) |=> (rd_data[7:1] == 7'd0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_op == 3'd0 || req_op == 3'd7) |-> !mem_we);

endmodule

bind spad_ram spad_ram_chk u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .req_op   (req_op),
  .bank_wr  (bank_wr),
  .bank_sel (bank_sel),
  .bank_q   (bank_q),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .old_byte (old_byte),
  .new_byte (new_byte),
  .rd_data  (rd_data),
  .rd_valid (rd_valid)
);

// File: tb/spad_ram_bench.sv
`timescale 1ns/1ps
module spad_ram_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] req_op;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_bit;
  logic       bank_wr;
  logic [1:0] bank_sel;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_run;
  int n_fail;

  logic [7:0] m [128];
  logic [1:0] m_bank;
  logic [7:0] exp_rd;
  logic       exp_vld;

  spad_ram u_spad_ram (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_bit(req_bit), .bank_wr(bank_wr),
    .bank_sel(bank_sel), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One request per call: drive at a falling edge, model at the rising edge,
  // compare at the next falling edge.
  task automatic step(string tag, logic [2:0] op, logic [7:0] addr,
                      logic [7:0] wd, logic bv, logic bw, logic [1:0] bs);
    int a;
    req_op = op; req_addr = addr; req_wdata = wd; req_bit = bv;
    bank_wr = bw; bank_sel = bs;
    @(posedge clk);
    exp_vld = 1'b0;
    case (op)
      3'd1: begin a = addr & 8'h7F; exp_rd = m[a]; exp_vld = 1'b1; end
      3'd2: begin a = addr & 8'h7F; m[a] = wd; end
      3'd3: begin a = m_bank * 8 + (addr & 8'h07); exp_rd = m[a]; exp_vld = 1'b1; end
      3'd4: begin a = m_bank * 8 + (addr & 8'h07); m[a] = wd; end
      3'd5: begin
        a = 32 + ((addr & 8'h7F) >> 3);
        exp_rd = {7'd0, m[a][addr & 8'h07]}; exp_vld = 1'b1;
      end
      3'd6: begin a = 32 + ((addr & 8'h7F) >> 3); m[a][addr & 8'h07] = bv; end
      default: ;
    endcase
    if (bw) m_bank = bs;
    @(negedge clk);
    check8({tag, " rd_valid"}, {7'd0, rd_valid}, {7'd0, exp_vld});
    check8({tag, " rd_data"}, rd_data, exp_rd);
  endtask

  task automatic idle1();
    step("R9", 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    req_op = 3'd0; req_addr = '0; req_wdata = '0; req_bit = 1'b0;
    bank_wr = 1'b0; bank_sel = 2'd0;
    m_bank = 2'd0; exp_rd = 8'h00; exp_vld = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check8("R8 reset rd_data", rd_data, 8'h00);
    check8("R8 reset rd_valid", {7'd0, rd_valid}, 8'h00);

    // Fill every byte
    for (int i = 0; i < 128; i++)
      step("R1 fill", 3'd2, 8'(i), 8'((i * 37 + 5) & 8'hFF), 1'b0, 1'b0, 2'd0);

    // R1: reads of several kinds of location
    step("R1", 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R1", 3'd1, 8'h25, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R1", 3'd1, 8'h7F, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R1", 3'd2, 8'h50, 8'hA5, 1'b0, 1'b0, 2'd0);
    step("R1", 3'd1, 8'h50, 8'h00, 1'b0, 1'b0, 2'd0);

    // R2: top address bit ignored
    step("R2", 3'd2, 8'h85, 8'h3C, 1'b0, 1'b0, 2'd0);
    step("R2", 3'd1, 8'h05, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R2", 3'd1, 8'hD0, 8'h00, 1'b0, 1'b0, 2'd0);

    // R4: bank 0 after reset; R3 register mapping
    step("R4", 3'd3, 8'h03, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R4", 3'd4, 8'h01, 8'h11, 1'b0, 1'b1, 2'd2);
    step("R4", 3'd1, 8'h01, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R3", 3'd4, 8'h01, 8'h77, 1'b0, 1'b0, 2'd0);
    step("R3", 3'd1, 8'h11, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R3", 3'd2, 8'h1F, 8'hE1, 1'b0, 1'b1, 2'd3);
    step("R3", 3'd3, 8'hFF, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R3", 3'd1, 8'h01, 8'h00, 1'b0, 1'b0, 2'd0);

    // R5 / R6 / R7: bit access
    step("R5", 3'd6, 8'h0A, 8'h00, 1'b1, 1'b0, 2'd0);
    step("R5", 3'd1, 8'h21, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R5", 3'd6, 8'h7F, 8'hFF, 1'b0, 1'b0, 2'd0);
    step("R5", 3'd1, 8'h2F, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R5", 3'd6, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R5", 3'd1, 8'h20, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R6", 3'd5, 8'h0A, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R6", 3'd5, 8'h7F, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R7", 3'd1, 8'h0A, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R7", 3'd5, 8'h8A, 8'h00, 1'b0, 1'b0, 2'd0);

    // R8 / R9: hold and idle codes
    step("R8", 3'd1, 8'h40, 8'h00, 1'b0, 1'b0, 2'd0);
    idle1();
    step("R9", 3'd7, 8'h40, 8'h00, 1'b1, 1'b0, 2'd0);
    step("R9", 3'd0, 8'h2A, 8'hFF, 1'b1, 1'b0, 2'd0);
    step("R9", 3'd1, 8'h40, 8'h00, 1'b0, 1'b0, 2'd0);
    step("R9", 3'd1, 8'h2A, 8'h00, 1'b0, 1'b0, 2'd0);

    // Mixed traffic against the model
    for (int k = 0; k < 3000; k++)
      step("RND", 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)));

    // Final sweep of all contents
    for (int i = 0; i < 128; i++)
      step("R1 sweep", 3'd1, 8'(i), 8'h00, 1'b0, 1'b0, 2'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule